// File: doc/BRIEF.md
# Programmable Address Window Decoder

The block sorts each incoming bus address into one of a small set of programmable address windows. Every window holds an enable bit, a base page, a size mask, a target identifier and an attribute byte. A request presents a 32-bit address with a valid strobe. One clock later the block returns whether any window claimed the address and, if one did, which window it was, its target and its attribute. If two or more enabled windows claim the same address, the block also raises an overlap flag.

Window sizes are powers of two in 64 KB steps. The size mask is a 16-bit value that must be a run of ones starting at bit 0, followed only by zeros. Each one in the run doubles the window. With no ones the window is 64 KB, 0x00FF gives 16 MB and 0x07FF gives 128 MB. Only the page bits above the window size are compared with the base, so base bits under the mask do not matter. A mask that is not such a run is reported as malformed, and that window then stays inert. Windows are programmed through a simple write port that loads a whole window in one cycle.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, all windows are disabled with zero base, size, target and attribute, and `size_err` is all zero. Also after reset, `rsp_valid` and `rsp_hit` are 0, `rsp_tgt` equals DEFAULT_TGT (4'hF), and `rsp_attr` is 0.
- R2: An enabled window whose size mask holds n contiguous ones from bit 0 covers 64 KB × 2^n bytes, starting at its base. The run may be 0 ones (64 KB), 8 ones (16 MB) or 11 ones (128 MB).
- R3: Request address bits [31:16] are compared with the base only where the size mask bit is 0. Base bits under mask ones have no effect on which addresses hit.
- R4: A size mask that is not a run of ones starting at bit 0 sets bit i of `size_err` for window i, and that window never hits. Correcting the mask clears the bit.
- R5: A window whose enable bit is 0 never hits, whatever its base and size.
- R6: When more than one window hits, the lowest-numbered window is reported and `rsp_overlap` is 1. With exactly one hit, `rsp_overlap` is 0.
- R7: On a miss, `rsp_hit` is 0, `rsp_win` is 0, `rsp_tgt` equals DEFAULT_TGT, `rsp_attr` is 0 and `rsp_overlap` is 0.
- R8: `rsp_valid` is `req_valid` delayed by exactly one clock. The response fields change only in the cycle after a request and hold their values while no request is presented.
- R9: A write with `cfg_we`=1 loads the enable, base, size, target and attribute of window `cfg_idx` at the clock edge. A write whose `cfg_idx` is 6 or 7 changes no window. A request in the same cycle as a write sees the old settings.
- R10: On a hit, `rsp_win`, `rsp_tgt` and `rsp_attr` are the index, target and attribute of the reported window, and requests may be presented on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_en | input | 1 | Enable bit written to the window |
| cfg_base | input | 16 | Base page, address bits [31:16] |
| cfg_size | input | 16 | Size mask, run of ones from bit 0 |
| cfg_tgt | input | 4 | Target identifier |
| cfg_attr | input | 8 | Attribute byte |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_win | output | 3 | Index of the reported window |
| rsp_tgt | output | 4 | Target of the reported window or default |
| rsp_attr | output | 8 | Attribute of the reported window or zero |
| rsp_overlap | output | 1 | More than one window claimed the address |
| size_err | output | 6 | Per-window malformed size mask flag |

## Verification
Some rules are checked on every cycle: the one-cycle valid delay, the hold of response fields while no request is presented, the default values on a miss, overlap only alongside a hit, an in-range reported index, and that a window flagged as malformed is never the reported hit. Other behaviour depends on the programmed contents and on address arithmetic, so only the bench scenarios can show it. That covers the exact window extents at 64 KB, 16 MB and 128 MB, masking of the low base bits, which window wins under overlap, disabled windows, and writes to nonexistent indices. For these, a reference model in the bench predicts the results.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
package awd_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 16;
  localparam int MASK_W     = ADDR_W - PAGE_SHIFT;
  localparam int TGT_W      = 4;
  localparam int ATTR_W     = 8;

  typedef struct packed {
    logic              en;
    logic [MASK_W-1:0] base;
    logic [MASK_W-1:0] size;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
  } win_cfg_t;
endpackage

// File: rtl/awd_win_regs.sv
`timescale 1ns/1ps
module awd_win_regs #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  awd_pkg::win_cfg_t                wr_cfg,
  output awd_pkg::win_cfg_t [NUM_WIN-1:0]  cfg_o
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    awd_pkg::win_cfg_t cur_q, nxt;
    logic              load;

    assign load = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      nxt = cur_q;
      if (load) nxt = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else if (load) cur_q <= nxt;
    end

    assign cfg_o[i] = cur_q;
  end
endmodule

// File: rtl/awd_win_match.sv
`timescale 1ns/1ps
module awd_win_match (
  input  awd_pkg::win_cfg_t               cfg,
  input  logic [awd_pkg::MASK_W-1:0]      page,
  output logic                            hit,
  output logic                            size_bad
);
  localparam int MW = awd_pkg::MASK_W;
  logic [MW-1:0] size_inc;
  logic [MW-1:0] diff;

  always_comb begin
    size_inc = cfg.size + MW'(1);
    size_bad = |(cfg.size & size_inc);
    diff     = (page ^ cfg.base) & ~cfg.size;
    hit      = cfg.en && !size_bad && (diff == '0);
  end
endmodule

// File: rtl/awd_prio_sel.sv
`timescale 1ns/1ps
module awd_prio_sel #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic               multi
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
    multi = |(hits & (hits - NUM_WIN'(1)));
  end
endmodule

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder #(
  parameter int                        NUM_WIN     = 6,
  parameter logic [awd_pkg::TGT_W-1:0] DEFAULT_TGT = 4'hF,
  localparam int                       IDX_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic                          cfg_en,
  input  logic [awd_pkg::MASK_W-1:0]    cfg_base,
  input  logic [awd_pkg::MASK_W-1:0]    cfg_size,
  input  logic [awd_pkg::TGT_W-1:0]     cfg_tgt,
  input  logic [awd_pkg::ATTR_W-1:0]    cfg_attr,
  input  logic                          req_valid,
  input  logic [awd_pkg::ADDR_W-1:0]    req_addr,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic [IDX_W-1:0]              rsp_win,
  output logic [awd_pkg::TGT_W-1:0]     rsp_tgt,
  output logic [awd_pkg::ATTR_W-1:0]    rsp_attr,
  output logic                          rsp_overlap,
  output logic [NUM_WIN-1:0]            size_err
);
  import awd_pkg::*;

  win_cfg_t                 wr_cfg;
  win_cfg_t [NUM_WIN-1:0]   cfg;
  logic [MASK_W-1:0]        page;
  logic [NUM_WIN-1:0]       hits;
  logic                     any_hit;
  logic                     multi_hit;
  logic [IDX_W-1:0]         win_idx;
  win_cfg_t                 sel_cfg;

  logic                     hit_n, ovl_n;
  logic [IDX_W-1:0]         win_n;
  logic [TGT_W-1:0]         tgt_n;
  logic [ATTR_W-1:0]        attr_n;

  assign wr_cfg = '{en: cfg_en, base: cfg_base, size: cfg_size,
                    tgt: cfg_tgt, attr: cfg_attr};

  awd_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_cfg (wr_cfg),
    .cfg_o  (cfg)
  );

  assign page = req_addr[ADDR_W-1:PAGE_SHIFT];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    awd_win_match u_match (
      .cfg      (cfg[i]),
      .page     (page),
      .hit      (hits[i]),
      .size_bad (size_err[i])
    );
  end

  awd_prio_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .hits  (hits),
    .any   (any_hit),
    .idx   (win_idx),
    .multi (multi_hit)
  );

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_idx == IDX_W'(i)) sel_cfg = cfg[i];
    end
  end

  // Next-state for the response fields
  always_comb begin
    hit_n  = any_hit;
    ovl_n  = any_hit && multi_hit;
    if (any_hit) begin
      win_n  = win_idx;
      tgt_n  = sel_cfg.tgt;
      attr_n = sel_cfg.attr;
    end else begin
      win_n  = '0;
      tgt_n  = DEFAULT_TGT;
      attr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit     <= 1'b0;
      rsp_win     <= '0;
      rsp_tgt     <= DEFAULT_TGT;
      rsp_attr    <= '0;
      rsp_overlap <= 1'b0;
    end else if (req_valid) begin
      rsp_hit     <= hit_n;
      rsp_win     <= win_n;
      rsp_tgt     <= tgt_n;
      rsp_attr    <= attr_n;
      rsp_overlap <= ovl_n;
    end
  end
endmodule

// File: rtl/awd_checker.sv
`timescale 1ns/1ps
module awd_checker #(
  parameter int                        NUM_WIN     = 6,
  parameter int                        IDX_W       = 3,
  parameter logic [awd_pkg::TGT_W-1:0] DEFAULT_TGT = 4'hF
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic [IDX_W-1:0]             rsp_win,
  input logic [awd_pkg::TGT_W-1:0]    rsp_tgt,
  input logic [awd_pkg::ATTR_W-1:0]   rsp_attr,
  input logic                         rsp_overlap,
  input logic [NUM_WIN-1:0]           size_err
);
  localparam int ERR_W = 2 ** IDX_W;
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= ERR_W'(size_err);
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_win) && $stable(rsp_tgt)
                    && $stable(rsp_attr) && $stable(rsp_overlap))); // R8
  AST_MISS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_tgt == DEFAULT_TGT && rsp_attr == '0
                                 && rsp_win == '0 && !rsp_overlap)); // R7
  AST_OVERLAP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_overlap |-> rsp_hit); // R6
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN)); // R10
  AST_BAD_SIZE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !err_q[rsp_win]); // R4
endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .DEFAULT_TGT(DEFAULT_TGT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_tgt(rsp_tgt), .rsp_attr(rsp_attr),
  .rsp_overlap(rsp_overlap), .size_err(size_err)
);

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  localparam int         NW  = 6;
  localparam logic [3:0] DEF = 4'hF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en, req_valid;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_base, cfg_size;
  logic [3:0]  cfg_tgt;
  logic [7:0]  cfg_attr;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_overlap;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_tgt;
  logic [7:0]  rsp_attr;
  logic [5:0]  size_err;

  always #2.5 clk = ~clk;

  addr_window_decoder #(.NUM_WIN(NW), .DEFAULT_TGT(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_tgt(cfg_tgt), .cfg_attr(cfg_attr),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_tgt(rsp_tgt), .rsp_attr(rsp_attr),
    .rsp_overlap(rsp_overlap), .size_err(size_err)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic        ovl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   errors = 0;
  int   checks = 0;

  logic        m_en   [NW];
  logic [15:0] m_base [NW];
  logic [15:0] m_size [NW];
  logic [3:0]  m_tgt  [NW];
  logic [7:0]  m_attr [NW];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit run_ok(input logic [15:0] s, output int ones);
    bit seen_zero = 0;
    ones = 0;
    for (int b = 0; b < 16; b++) begin
      if (s[b]) begin
        if (seen_zero) return 0;
        ones++;
      end else seen_zero = 1;
    end
    return 1;
  endfunction

  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    int   n;
    longint unsigned span, start;
    e.hit = 0; e.win = 0; e.tgt = DEF; e.attr = 0; e.ovl = 0; e.tag = tag;
    for (int i = 0; i < NW; i++) begin
      if (m_en[i] && run_ok(m_size[i], n)) begin
        span  = 64'h10000 << n;
        start = {32'h0, m_base[i], 16'h0} & ~(span - 1);
        if (longint'(a) >= start && longint'(a) < start + span) begin
          if (e.hit) e.ovl = 1;
          else begin
            e.hit = 1; e.win = 3'(i); e.tgt = m_tgt[i]; e.attr = m_attr[i];
          end
        end
      end
    end
    return e;
  endfunction

  function automatic logic [5:0] predict_err();
    logic [5:0] v;
    int n;
    for (int i = 0; i < NW; i++) v[i] = !run_ok(m_size[i], n);
    return v;
  endfunction

  task automatic wr(input logic [2:0] idx, input logic en, input logic [15:0] base,
                    input logic [15:0] size, input logic [3:0] tgt, input logic [7:0] attr);
    @(posedge clk); #1;
    req_valid = 0;
    cfg_we = 1; cfg_idx = idx; cfg_en = en; cfg_base = base;
    cfg_size = size; cfg_tgt = tgt; cfg_attr = attr;
    if (int'(idx) < NW) begin
      m_en[idx] = en; m_base[idx] = base; m_size[idx] = size;
      m_tgt[idx] = tgt; m_attr[idx] = attr;
    end
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic req(input logic [31:0] a, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(predict(a, tag));
    req_valid = 1; req_addr = a;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      req_valid = 0;
    end
  endtask

  // Monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) check(0, "R8", "response without request", 32'(rsp_valid), 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_hit === e.hit, e.tag, "hit", 32'(rsp_hit), 32'(e.hit));
        check(rsp_win === e.win, e.tag, "win", 32'(rsp_win), 32'(e.win));
        check(rsp_tgt === e.tgt, e.tag, "tgt", 32'(rsp_tgt), 32'(e.tgt));
        check(rsp_attr === e.attr, e.tag, "attr", 32'(rsp_attr), 32'(e.attr));
        check(rsp_overlap === e.ovl, e.tag, "overlap", 32'(rsp_overlap), 32'(e.ovl));
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic       h_hit, h_ovl;
    logic [2:0] h_win;
    logic [3:0] h_tgt;
    logic [7:0] h_attr;
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_base[i] = 0; m_size[i] = 0; m_tgt[i] = 0; m_attr[i] = 0;
    end
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_base = 0; cfg_size = 0;
    cfg_tgt = 0; cfg_attr = 0; req_valid = 0; req_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid === 0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    check(rsp_hit === 0, "R1", "rsp_hit", 32'(rsp_hit), 0);
    check(rsp_tgt === DEF, "R1", "rsp_tgt", 32'(rsp_tgt), 32'(DEF));
    check(rsp_attr === 0, "R1", "rsp_attr", 32'(rsp_attr), 0);
    check(size_err === 6'b0, "R1", "size_err", 32'(size_err), 0);
    req(32'h1000_0000, "R1");
    req(32'h0000_0000, "R1");

    // R2: 64 KB window, R7: misses around it
    wr(0, 1, 16'h1000, 16'h0000, 4'h1, 8'h11);
    req(32'h1000_0000, "R2");
    req(32'h1000_FFFF, "R2");
    req(32'h1001_0000, "R2");
    req(32'h0FFF_FFFF, "R7");

    // R3: low base bits under the mask are ignored; R2: 16 MB extent
    wr(1, 1, 16'h20AB, 16'h00FF, 4'h2, 8'h22);
    req(32'h2000_0000, "R3");
    req(32'h20FF_FFFF, "R2");
    req(32'h2100_0000, "R2");
    req(32'h1FFF_FFFF, "R7");

    // R2: 128 MB extent
    wr(2, 1, 16'h4000, 16'h07FF, 4'h3, 8'h33);
    req(32'h4000_0000, "R2");
    req(32'h47FF_FFFF, "R2");
    req(32'h4800_0000, "R2");

    // R4: malformed mask flagged and inert, then corrected
    wr(3, 1, 16'h6000, 16'h0005, 4'h4, 8'h44);
    @(negedge clk);
    check(size_err === predict_err(), "R4", "size_err bad", 32'(size_err), 32'(predict_err()));
    check(size_err[3] === 1'b1, "R4", "size_err[3]", 32'(size_err[3]), 1);
    req(32'h6000_0000, "R4");
    req(32'h6004_0000, "R4");
    wr(3, 1, 16'h6000, 16'h0007, 4'h4, 8'h44);
    @(negedge clk);
    check(size_err === 6'b0, "R4", "size_err fixed", 32'(size_err), 0);
    req(32'h6004_0000, "R4");
    req(32'h6008_0000, "R4");

    // R5: disabled window, R9: enabling through a write
    wr(4, 0, 16'h7000, 16'h0000, 4'h5, 8'h55);
    req(32'h7000_0000, "R5");
    wr(4, 1, 16'h7000, 16'h0000, 4'h5, 8'h55);
    req(32'h7000_0000, "R9");

    // R6: overlap, lowest index wins
    wr(5, 1, 16'h1000, 16'h000F, 4'h6, 8'h66);
    req(32'h1000_0000, "R6");
    req(32'h1008_0000, "R6");

    // R9: writes to nonexistent windows change nothing
    wr(7, 1, 16'h9000, 16'h0000, 4'h7, 8'h77);
    wr(6, 1, 16'hA000, 16'h0000, 4'h8, 8'h88);
    req(32'h9000_0000, "R9");
    req(32'hA000_0000, "R9");
    @(negedge clk);
    check(size_err === 6'b0, "R9", "size_err after ignored write", 32'(size_err), 0);

    // R10: back-to-back stream across windows
    req(32'h1000_1234, "R10");
    req(32'h2080_0000, "R10");
    req(32'h4123_4567, "R10");
    req(32'h6001_0000, "R10");
    req(32'h7000_8000, "R10");
    req(32'h100F_FFFF, "R10");
    req(32'hF000_0000, "R10");
    req(32'h4000_0000, "R10");

    // R8: fields hold while idle
    idle(2);
    @(negedge clk);
    h_hit = rsp_hit; h_win = rsp_win; h_tgt = rsp_tgt; h_attr = rsp_attr; h_ovl = rsp_overlap;
    req_addr = 32'h1000_0000;
    idle(3);
    @(negedge clk);
    check(rsp_valid === 0, "R8", "rsp_valid idle", 32'(rsp_valid), 0);
    check({rsp_hit, rsp_win, rsp_tgt, rsp_attr, rsp_overlap} ===
          {h_hit, h_win, h_tgt, h_attr, h_ovl}, "R8", "held fields",
          32'({rsp_hit, rsp_win, rsp_tgt, rsp_attr, rsp_overlap}),
          32'({h_hit, h_win, h_tgt, h_attr, h_ovl}));
    check(exp_q.size() == 0, "R8", "pending responses", 32'(exp_q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule